// File: doc/BRIEF.md
# External Master Prefetch and Gather Bridge

This block lets an external bus master of 8, 16 or 32 bits reach a 64-bit system bus through one shared 32-byte staging buffer. It presents a single-beat request/ready port to the master and a request/acknowledge burst port to the system bus. A read miss fetches whole doublewords into the buffer. A burst read fetches several doublewords at once. Later reads that land on a buffered doubleword are answered in the same cycle, with no system traffic.

Writes come in two kinds. A single write is not buffered: each item goes out as its own one-beat system write. Writes flagged as burst are accepted at once into the buffer. When the item marked last arrives, the collected bytes go out as one multi-beat system write.

The controller is a five-state machine:
- IDLE serves read hits and accepts gathered writes.
- FETCH runs a system read burst that fills the buffer.
- SWR holds a single write on the system bus.
- SWR_ACK completes that write toward the master.
- FLUSH writes out the gathered data.

Transitions:
- IDLE goes to FETCH on a read miss.
- IDLE goes to SWR on a single write.
- IDLE goes to FLUSH on a last burst write, or when a pending gather meets any other request.
- FETCH goes back to IDLE after its final beat.
- SWR goes to SWR_ACK on acknowledge, and SWR_ACK goes to IDLE.
- FLUSH goes back to IDLE after its final beat.

Top module: `xbm_bridge`

## Requirements
- R1: `cfg_width` selects the master width: 0 is 8 bits, 1 is 16 bits, 2 (or 3) is 32 bits. An item of N bytes sits in the low N bytes of `ext_wdata`/`ext_rdata`. It maps to the doubleword bytes starting at `ext_addr[2:0]` rounded down to a multiple of N.
- R2: `ext_be[k]` enables item byte k. Disabled bytes are left unwritten in memory (their `sb_be` bit is 0) and read back as zero.
- R3: A read that misses fetches the doubleword holding `ext_addr` with one system read (`sb_we`=0, `sb_len`=1, `sb_addr` the doubleword address). The item is then returned from that doubleword.
- R4: A read whose doubleword is valid in the buffer is completed with `ext_rdy` high in the same cycle, without raising `sb_req`.
- R5: A burst read miss at doubleword index d (`ext_addr[4:3]`) fetches min(`cfg_pf`+1, 4-d) doublewords in one system burst starting at d. The prefetch never wraps past the 32-byte block.
- R6: A read to a doubleword of the current block that was not prefetched starts a new fetch.
- R7: Any accepted write invalidates all buffered read data. A read to a different 32-byte block discards the buffered block.
- R8: Each single write (`ext_burst`=0) produces exactly one one-beat system write carrying that item's bytes. `ext_rdy` rises only after the acknowledge.
- R9: Burst writes are accepted with `ext_rdy` high in the same cycle, with no system traffic. After the write marked `ext_last`, one system write burst covers the lowest through highest doubleword touched, and each beat's `sb_be` holds the gathered bytes.
- R10: While a gather is open, any request other than a burst write to the same block first causes the gathered data to be flushed. Only then is that request handled.
- R11: After reset `sb_req` and `ext_rdy` are low. On the system bus, `sb_req`, `sb_addr`, `sb_len` and `sb_we` hold steady until the final acknowledge, and each acknowledge moves one doubleword beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_width | input | 2 | Master width select |
| cfg_pf | input | 2 | Burst prefetch count minus one |
| ext_req | input | 1 | Master transfer request |
| ext_rd | input | 1 | 1 read, 0 write |
| ext_burst | input | 1 | Transfer belongs to a burst |
| ext_last | input | 1 | Last transfer of a burst |
| ext_addr | input | 32 | Byte address |
| ext_be | input | 4 | Item byte enables |
| ext_wdata | input | 32 | Write item |
| ext_rdata | output | 32 | Read item |
| ext_rdy | output | 1 | Transfer completes this cycle |
| sb_req | output | 1 | System request |
| sb_we | output | 1 | System write |
| sb_addr | output | 32 | Doubleword start address |
| sb_len | output | 3 | Beats in the transaction |
| sb_be | output | 8 | Beat byte mask |
| sb_wdata | output | 64 | Beat write data |
| sb_rdata | input | 64 | Beat read data |
| sb_ack | input | 1 | Beat acknowledge |

## Verification
Two of the block's jobs share one buffer and can collide in a single cycle. The first burst write can arrive while prefetched read data is still valid: in that edge it must both invalidate the read data and start a gather in the same storage. Likewise, a pending gather can meet a read or a burst write to another block; the flush must then win before that request is served. Directed sequences set up both collisions, and randomized mixes of reads, writes and gathers at all widths provoke them again. The results are judged by the count, length, address and direction of completed system transactions, by every read item, and by a final comparison of system memory against a byte-level reference model.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SWR,
        S_SWR_ACK,
        S_FLUSH
    } xbm_state_e;
endpackage

// File: rtl/xbm_lanes.sv
module xbm_lanes (
    input  logic [1:0]  width,
    input  logic [2:0]  addr_lo,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic [63:0] dw_in,
    output logic [7:0]  mask8,
    output logic [63:0] wdw,
    output logic [31:0] rdata
);
    logic [2:0] base;
    int         nb;

    always_comb begin
        nb    = (width == 2'd0) ? 1 : (width == 2'd1) ? 2 : 4;
        base  = addr_lo & ~(3'(nb - 1));
        mask8 = '0;
        wdw   = '0;
        rdata = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < nb && be[k]) begin
                mask8[int'(base) + k]          = 1'b1;
                wdw[(int'(base) + k) * 8 +: 8] = wdata[k * 8 +: 8];
                rdata[k * 8 +: 8]              = dw_in[(int'(base) + k) * 8 +: 8];
            end
        end
    end
endmodule

// File: rtl/xbm_store.sv
module xbm_store #(
    parameter int NDW   = 4,
    parameter int IDX_W = $clog2(NDW)
) (
    input  logic             clk,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [63:0]      fill_dat,
    input  logic             byte_we,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [7:0]       byte_mask,
    input  logic [63:0]      byte_dat,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [63:0]      rd_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [63:0]      rd_b
);
    logic [63:0] ent [NDW];

    for (genvar g = 0; g < NDW; g++) begin : g_ent
        logic [63:0] q;
        always_ff @(posedge clk) begin
            if (fill_we && fill_idx == IDX_W'(g)) begin
                q <= fill_dat;
            end else if (byte_we && byte_idx == IDX_W'(g)) begin
                for (int b = 0; b < 8; b++) begin
                    if (byte_mask[b]) q[b * 8 +: 8] <= byte_dat[b * 8 +: 8];
                end
            end
        end
        assign ent[g] = q;
    end

    assign rd_a = ent[rd_idx_a];
    assign rd_b = ent[rd_idx_b];
endmodule

// File: rtl/xbm_bridge.sv
module xbm_bridge
    import xbm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NDW     = 4,
    localparam int IDX_W   = $clog2(NDW),
    localparam int BLK_LSB = IDX_W + 3,
    localparam int TAG_W   = ADDR_W - BLK_LSB,
    localparam int LEN_W   = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic [IDX_W-1:0]  cfg_pf,
    input  logic              ext_req,
    input  logic              ext_rd,
    input  logic              ext_burst,
    input  logic              ext_last,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [3:0]        ext_be,
    input  logic [31:0]       ext_wdata,
    output logic [31:0]       ext_rdata,
    output logic              ext_rdy,
    output logic              sb_req,
    output logic              sb_we,
    output logic [ADDR_W-1:0] sb_addr,
    output logic [LEN_W-1:0]  sb_len,
    output logic [7:0]        sb_be,
    output logic [63:0]       sb_wdata,
    input  logic [63:0]       sb_rdata,
    input  logic              sb_ack
);
    xbm_state_e state_q, state_nx;

    logic [TAG_W-1:0]       tag_q;
    logic                   tag_ok_q;
    logic [NDW-1:0]         vld_q;
    logic                   gath_q;
    logic [NDW-1:0][7:0]    gmask_q;
    logic [IDX_W-1:0]       glo_q, ghi_q, f_start_q, f_end_q, beat_q;
    logic [ADDR_W-4:0]      sw_dwa_q;
    logic [7:0]             sw_mask_q;
    logic [63:0]            sw_dat_q;

    logic [TAG_W-1:0]  blk;
    logic [IDX_W-1:0]  d_idx, f_end_nx, glo_nx, ghi_nx;
    logic              same_blk, rd_hit, rd_miss, gw_ok, need_flush, sw_go;
    logic [7:0]        ln_mask;
    logic [63:0]       ln_wdw, rd_a, rd_b;

    assign blk      = ext_addr[ADDR_W-1:BLK_LSB];
    assign d_idx    = ext_addr[BLK_LSB-1:3];
    assign same_blk = tag_ok_q && (tag_q == blk);

    // Request decode, meaningful in IDLE only
    always_comb begin
        rd_hit     = ext_req && ext_rd && !gath_q && same_blk && vld_q[d_idx];
        rd_miss    = ext_req && ext_rd && !gath_q && !rd_hit;
        gw_ok      = ext_req && !ext_rd && ext_burst && (!gath_q || same_blk);
        need_flush = gath_q && ext_req && !gw_ok;
        sw_go      = ext_req && !ext_rd && !ext_burst && !gath_q;
    end

    // Prefetch span, clipped at the block end
    always_comb begin
        int cnt;
        int e;
        cnt = ext_burst ? int'(cfg_pf) + 1 : 1;
        e   = int'(d_idx) + cnt - 1;
        if (e > NDW - 1) e = NDW - 1;
        f_end_nx = IDX_W'(e);
        glo_nx   = (gath_q && glo_q < d_idx) ? glo_q : d_idx;
        ghi_nx   = (gath_q && ghi_q > d_idx) ? ghi_q : d_idx;
    end

    xbm_lanes u_lanes (
        .width   (cfg_width),
        .addr_lo (ext_addr[2:0]),
        .be      (ext_be),
        .wdata   (ext_wdata),
        .dw_in   (rd_a),
        .mask8   (ln_mask),
        .wdw     (ln_wdw),
        .rdata   (ext_rdata)
    );

    xbm_store #(.NDW(NDW)) u_store (
        .clk       (clk),
        .fill_we   (state_q == S_FETCH && sb_ack),
        .fill_idx  (beat_q),
        .fill_dat  (sb_rdata),
        .byte_we   (state_q == S_IDLE && gw_ok),
        .byte_idx  (d_idx),
        .byte_mask (ln_mask),
        .byte_dat  (ln_wdw),
        .rd_idx_a  (d_idx),
        .rd_a      (rd_a),
        .rd_idx_b  (beat_q),
        .rd_b      (rd_b)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // Next-state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (need_flush)            state_nx = S_FLUSH;
                else if (rd_miss)          state_nx = S_FETCH;
                else if (sw_go)            state_nx = S_SWR;
                else if (gw_ok && ext_last) state_nx = S_FLUSH;
            end
            S_FETCH:   if (sb_ack && beat_q == f_end_q) state_nx = S_IDLE;
            S_SWR:     if (sb_ack) state_nx = S_SWR_ACK;
            S_SWR_ACK: state_nx = S_IDLE;
            S_FLUSH:   if (sb_ack && beat_q == ghi_q) state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Buffer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q     <= '0;
            tag_ok_q  <= 1'b0;
            vld_q     <= '0;
            gath_q    <= 1'b0;
            gmask_q   <= '0;
            glo_q     <= '0;
            ghi_q     <= '0;
            f_start_q <= '0;
            f_end_q   <= '0;
            beat_q    <= '0;
            sw_dwa_q  <= '0;
            sw_mask_q <= '0;
            sw_dat_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (need_flush) begin
                        beat_q <= glo_q;
                    end else if (rd_miss) begin
                        if (!same_blk) vld_q <= '0;
                        tag_q     <= blk;
                        tag_ok_q  <= 1'b1;
                        f_start_q <= d_idx;
                        f_end_q   <= f_end_nx;
                        beat_q    <= d_idx;
                    end else if (sw_go) begin
                        vld_q     <= '0;
                        sw_dwa_q  <= ext_addr[ADDR_W-1:3];
                        sw_mask_q <= ln_mask;
                        sw_dat_q  <= ln_wdw;
                    end else if (gw_ok) begin
                        vld_q    <= '0;
                        tag_q    <= blk;
                        tag_ok_q <= 1'b1;
                        gath_q   <= 1'b1;
                        glo_q    <= glo_nx;
                        ghi_q    <= ghi_nx;
                        beat_q   <= glo_nx;
                        for (int i = 0; i < NDW; i++) begin
                            if (i == int'(d_idx))
                                gmask_q[i] <= (gath_q ? gmask_q[i] : 8'h00) | ln_mask;
                            else if (!gath_q)
                                gmask_q[i] <= 8'h00;
                        end
                    end
                end
                S_FETCH: begin
                    if (sb_ack) begin
                        vld_q[beat_q] <= 1'b1;
                        beat_q        <= beat_q + 1'b1;
                    end
                end
                S_FLUSH: begin
                    if (sb_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == ghi_q) begin
                            gath_q   <= 1'b0;
                            gmask_q  <= '0;
                            tag_ok_q <= 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ext_rdy  = 1'b0;
        sb_req   = 1'b0;
        sb_we    = 1'b0;
        sb_addr  = '0;
        sb_len   = '0;
        sb_be    = '0;
        sb_wdata = '0;
        unique case (state_q)
            S_IDLE:    ext_rdy = rd_hit || gw_ok;
            S_FETCH: begin
                sb_req  = 1'b1;
                sb_addr = {tag_q, f_start_q, 3'b000};
                sb_len  = LEN_W'(f_end_q) - LEN_W'(f_start_q) + LEN_W'(1);
            end
            S_SWR: begin
                sb_req   = 1'b1;
                sb_we    = 1'b1;
                sb_addr  = {sw_dwa_q, 3'b000};
                sb_len   = LEN_W'(1);
                sb_be    = sw_mask_q;
                sb_wdata = sw_dat_q;
            end
            S_SWR_ACK: ext_rdy = 1'b1;
            S_FLUSH: begin
                sb_req   = 1'b1;
                sb_we    = 1'b1;
                sb_addr  = {tag_q, glo_q, 3'b000};
                sb_len   = LEN_W'(ghi_q) - LEN_W'(glo_q) + LEN_W'(1);
                sb_be    = gmask_q[beat_q];
                sb_wdata = rd_b;
            end
            default: ;
        endcase
    end

    // R11
    sb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_req && !sb_ack |=> sb_req && $stable(sb_addr) && $stable(sb_len) && $stable(sb_we));

    // R4
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && ext_rdy && ext_rd |-> !sb_req);

    // R7
    wr_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && ext_rdy && !ext_rd |=> vld_q == '0);

    // R5
    fetch_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_req && !sb_we |-> (int'(sb_addr[BLK_LSB-1:3]) + int'(sb_len)) <= NDW);

    // R9
    gath_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && ext_rdy && !ext_rd && ext_burst |-> !sb_req);
endmodule

// File: tb/xbm_bridge_tb.sv
module xbm_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd2;
    logic [1:0]  cfg_pf = 2'd3;
    logic        ext_req = 0, ext_rd = 0, ext_burst = 0, ext_last = 0;
    logic [31:0] ext_addr = '0;
    logic [3:0]  ext_be = '0;
    logic [31:0] ext_wdata = '0;
    logic [31:0] ext_rdata;
    logic        ext_rdy;
    logic        sb_req, sb_we;
    logic [31:0] sb_addr;
    logic [2:0]  sb_len;
    logic [7:0]  sb_be;
    logic [63:0] sb_wdata;
    logic [63:0] sb_rdata;
    logic        sb_ack;

    always #5 clk = ~clk;

    xbm_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_pf(cfg_pf),
        .ext_req(ext_req), .ext_rd(ext_rd), .ext_burst(ext_burst), .ext_last(ext_last),
        .ext_addr(ext_addr), .ext_be(ext_be), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .ext_rdy(ext_rdy),
        .sb_req(sb_req), .sb_we(sb_we), .sb_addr(sb_addr), .sb_len(sb_len),
        .sb_be(sb_be), .sb_wdata(sb_wdata), .sb_rdata(sb_rdata), .sb_ack(sb_ack)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [63:0] mem [64];
    logic [7:0]  ref_b [512];

    // Slave bookkeeping
    int          tx_cnt = 0, bt = 0;
    logic        tx_we;
    logic [31:0] tx_addr;
    logic [2:0]  tx_len;
    logic        p_req = 0, p_we = 0;
    logic [31:0] p_addr = '0;
    logic [2:0]  p_len = '0;
    logic [7:0]  p_be = '0;
    logic [63:0] p_wd = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [31:0] a, input logic [3:0] be, input logic [1:0] w);
        logic [31:0] r;
        int nb, base;
        nb   = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        base = int'(a[2:0]) & ~(nb - 1);
        r = '0;
        for (int k = 0; k < nb; k++)
            if (be[k]) r[k * 8 +: 8] = ref_b[int'(a[8:3]) * 8 + base + k];
        return r;
    endfunction

    task automatic exp_wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] wd, input logic [1:0] w);
        int nb, base;
        nb   = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        base = int'(a[2:0]) & ~(nb - 1);
        for (int k = 0; k < nb; k++)
            if (be[k]) ref_b[int'(a[8:3]) * 8 + base + k] = wd[k * 8 +: 8];
    endtask

    // System-bus slave
    initial begin
        sb_ack = 0;
        sb_rdata = '0;
        forever begin
            @(negedge clk);
            if (sb_ack && p_req) begin
                int idx;
                idx = (int'(p_addr[8:3]) + bt) % 64;
                if (p_we)
                    for (int i = 0; i < 8; i++)
                        if (p_be[i]) mem[idx][i * 8 +: 8] = p_wd[i * 8 +: 8];
                bt++;
                if (bt == int'(p_len)) begin
                    tx_cnt++;
                    tx_we = p_we; tx_addr = p_addr; tx_len = p_len;
                    bt = 0;
                end
            end
            sb_ack = 0;
            p_req = sb_req; p_we = sb_we; p_addr = sb_addr;
            p_len = sb_len; p_be = sb_be; p_wd = sb_wdata;
            if (!rst_n) bt = 0;
            if (sb_req && rst_n && ($urandom % 4 != 0)) begin
                sb_ack = 1;
                sb_rdata = mem[(int'(sb_addr[8:3]) + bt) % 64];
            end
        end
    end

    task automatic xfer(input bit rd, input bit bu, input bit la, input logic [31:0] a,
                        input logic [3:0] be, input logic [31:0] wd, output logic [31:0] rdat);
        int t = 0;
        ext_req = 1; ext_rd = rd; ext_burst = bu; ext_last = la;
        ext_addr = a; ext_be = be; ext_wdata = wd;
        rdat = '0;
        while (1) begin
            @(negedge clk);
            if (ext_rdy === 1'b1) begin rdat = ext_rdata; break; end
            t++;
            if (t > 300) break;
        end
        @(posedge clk); #1;
        ext_req = 0;
        if (!rd) exp_wr(a, be, wd, cfg_width);
    endtask

    task automatic settle();
        int q = 0;
        for (int t = 0; t < 300 && q < 3; t++) begin
            @(negedge clk);
            q = sb_req ? 0 : q + 1;
        end
        @(posedge clk); #1;
    endtask

    task automatic rd_chk(input logic [31:0] a, input logic [3:0] be, input bit bu, input string req);
        logic [31:0] r, e;
        e = exp_rd(a, be, cfg_width);
        xfer(1, bu, 1, a, be, 0, r);
        chk(r === e, req, r, e);
    endtask

    task automatic mem_chk(input string req);
        int bad = 0;
        for (int j = 0; j < 64; j++)
            for (int b = 0; b < 8; b++)
                if (mem[j][b * 8 +: 8] !== ref_b[j * 8 + b]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        int t0;
        logic [31:0] r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 512; i++) ref_b[i] = 8'(i * 37 + 11);
        for (int j = 0; j < 64; j++)
            for (int b = 0; b < 8; b++) mem[j][b * 8 +: 8] = ref_b[j * 8 + b];

        repeat (3) @(posedge clk);
        #1;
        chk(sb_req === 1'b0 && ext_rdy === 1'b0, "R11 reset", {sb_req, ext_rdy}, 0);
        rst_n = 1;
        @(posedge clk); #1;

        // R3 single read miss, 32-bit
        cfg_width = 2; t0 = tx_cnt;
        rd_chk(32'h48, 4'hF, 0, "R3 data");
        chk(tx_cnt == t0 + 1 && tx_len == 1 && tx_addr == 32'h48 && !tx_we, "R3 txn", {tx_cnt - t0, tx_addr}, {32'd1, 32'h48});
        // R4 hit, R2 zeroed bytes
        t0 = tx_cnt;
        rd_chk(32'h4C, 4'b0101, 0, "R2 read be");
        chk(tx_cnt == t0, "R4 hit no txn", tx_cnt - t0, 0);
        cfg_width = 0; rd_chk(32'h4B, 4'h1, 0, "R1 byte width");
        cfg_width = 1; rd_chk(32'h4A, 4'b0010, 0, "R1 half width R2");
        chk(tx_cnt == t0, "R4 hits at narrow widths", tx_cnt - t0, 0);

        // R5 burst prefetch clipped at block end
        cfg_width = 2; cfg_pf = 3; t0 = tx_cnt;
        rd_chk(32'h88, 4'hF, 1, "R5 data");
        chk(tx_cnt == t0 + 1 && tx_len == 3 && tx_addr == 32'h88, "R5 len", tx_len, 3);
        rd_chk(32'h90, 4'hF, 1, "R5 data2");
        rd_chk(32'h9C, 4'hF, 1, "R5 data3");
        chk(tx_cnt == t0 + 1, "R5 prefetched hits", tx_cnt - t0, 1);
        // R6 doubleword below the prefetch
        rd_chk(32'h80, 4'hF, 0, "R6 data");
        chk(tx_cnt == t0 + 2 && tx_addr == 32'h80 && tx_len == 1, "R6 refetch", tx_addr, 32'h80);
        cfg_pf = 0; t0 = tx_cnt;
        rd_chk(32'hA0, 4'hF, 1, "R5 pf1");
        chk(tx_len == 1 && tx_cnt == t0 + 1, "R5 pf1 len", tx_len, 1);
        rd_chk(32'hA8, 4'hF, 1, "R6 burst past");
        chk(tx_cnt == t0 + 2 && tx_addr == 32'hA8, "R6 burst past txn", tx_addr, 32'hA8);
        // R7 block change
        t0 = tx_cnt;
        rd_chk(32'hA4, 4'hF, 0, "R7 same block hit");
        rd_chk(32'h48, 4'hF, 0, "R7 other block");
        chk(tx_cnt == t0 + 1, "R7 block switch refetch", tx_cnt - t0, 1);

        // R8 single write, then R7 invalidation by write
        t0 = tx_cnt;
        xfer(0, 0, 1, 32'h4C, 4'b0011, 32'hDEADBEEF, r);
        chk(tx_cnt == t0 + 1 && tx_we && tx_len == 1 && tx_addr == 32'h48, "R8 txn", tx_addr, 32'h48);
        rd_chk(32'h4C, 4'hF, 0, "R8 readback");
        chk(tx_cnt == t0 + 2, "R7 write invalidates", tx_cnt - t0, 2);

        // R9 gather: first burst write also invalidates live read data
        t0 = tx_cnt;
        xfer(0, 1, 0, 32'h4C, 4'hF, 32'h11223344, r);
        xfer(0, 1, 0, 32'h50, 4'b1001, 32'hA5A5A5A5, r);
        chk(tx_cnt == t0, "R9 no traffic while gathering", tx_cnt - t0, 0);
        xfer(0, 1, 1, 32'h58, 4'hF, 32'h01020304, r);
        settle();
        chk(tx_cnt == t0 + 1 && tx_we && tx_len == 3 && tx_addr == 32'h48, "R9 flush", {tx_len, tx_addr}, {3'd3, 32'h48});
        rd_chk(32'h4C, 4'hF, 0, "R9 readback");
        mem_chk("R9 memory");

        // R10 read interrupts gather
        t0 = tx_cnt;
        xfer(0, 1, 0, 32'h1C4, 4'hF, 32'hCAFEF00D, r);
        rd_chk(32'h1C4, 4'hF, 0, "R10 read after flush");
        chk(tx_cnt == t0 + 2, "R10 flush then fetch", tx_cnt - t0, 2);
        // R10 burst write to another block
        t0 = tx_cnt;
        xfer(0, 1, 0, 32'h1C8, 4'hF, 32'h0BADC0DE, r);
        xfer(0, 1, 1, 32'h180, 4'hF, 32'h600DF00D, r);
        settle();
        chk(tx_cnt == t0 + 2 && tx_addr == 32'h180, "R10 block change flush", tx_addr, 32'h180);
        mem_chk("R10 memory R2");

        // Randomized mix
        for (int n = 0; n < 200; n++) begin
            int op;
            logic [31:0] a;
            logic [3:0]  be;
            cfg_width = 2'($urandom % 4);
            cfg_pf = 2'($urandom % 4);
            a  = $urandom % 512;
            be = 4'($urandom);
            op = $urandom % 10;
            if (op < 4) rd_chk(a, be, 0, "R1 random read");
            else if (op < 6) rd_chk(a, be, 1, "R5 random burst read");
            else if (op < 8) xfer(0, 0, 1, a, be, $urandom, r);
            else begin
                int cnt = 1 + $urandom % 3;
                for (int k = 0; k < cnt; k++)
                    xfer(0, 1, k == cnt - 1 && ($urandom % 4 != 0),
                         {a[31:5], 5'($urandom)}, 4'($urandom), $urandom, r);
            end
        end
        rd_chk(32'h0, 4'hF, 0, "R10 final read");
        settle();
        mem_chk("R8 random memory");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule